// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Corrector

This block is the digital back end of a pipelined analog-to-digital converter whose analog chain is built from stages that each resolve 1.5 bits. Every stage hands over a 2-bit decision each clock. Because the analog chain is staggered, the stages are working on different samples at any given moment. The block delays each stage's decision stream by the right number of clocks so that all decisions for one sample meet in the same cycle. It then adds them with weights that overlap by one bit, which gives the final binary word.

The redundant three-level codes let the sum absorb comparator offsets in the analog stages. A code that no stage can legally produce is counted as the middle level, and it also sets an error flag that stays set. The block accepts one new sample per clock. An output valid follows the input valid after a fixed latency.

Top module: `pac_corrector`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_word` is 0 and `err_sticky` is 0.
- R2: Stage n (n = 1 to K, where stage 1 is nearest the analog input) drives `stage_codes[2n-1:2n-2]`. For a sample marked by `in_valid` in cycle t, stage n's code is presented in cycle t+n-1. Each result uses only the codes of its own sample.
- R3: The code values are 00 = 0, 01 = 1 and 10 = 2. `out_word` equals the sum over n of value_n·2^(K-n). It is K+1 bits wide and never exceeds 2^(K+1)-2. With K=6, all stages at 10 give 126 and all stages at 00 give 0.
- R4: If `in_valid` is high in cycle t, `out_valid` is high in cycle t+K and `out_word` holds that sample's result. Samples marked in consecutive cycles produce results in consecutive cycles. `out_valid` is low in cycles that follow no marked sample.
- R5: Once `err_sticky` is set, it stays set until reset.
- R6: `err_sticky` is set only when a marked sample carries code 11 in some stage. It rises in the same cycle as that sample's `out_valid`. Codes in slots not marked by `in_valid` never set it.
- R7: A stage code 11 adds the same amount as code 01.
- R8: While `out_valid` is low, `out_word` keeps the last result.
- R9: Let each stage decide ideally on an input x in (-Vref, Vref), where x ≤ -Vref/4 gives 00, x ≤ +Vref/4 gives 01 and higher x gives 10, and let each stage pass on the residue 2x - (value-1)·Vref. Then |out_word - (2^K - 1 + x·2^K/Vref)| < 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks that stage 1's code in this cycle starts a real sample |
| stage_codes | input | 2*NUM_STAGES | Current 2-bit decision of every stage, stage 1 in the low pair |
| out_valid | output | 1 | Corrected word is valid |
| out_word | output | NUM_STAGES+1 | Corrected binary result |
| err_sticky | output | 1 | An illegal stage code has been seen on a valid sample |

## Verification
The main sweep covers every input level on a grid fine enough that every residue stays an exact integer. It tries an ideal staggered stage model across the full input range, so each threshold crossing in every stage is reached. Every seventh slot is left unmarked and filled with illegal codes on all stages. This shows whether the alignment keeps samples apart and whether unmarked slots are ignored by the output and by the error flag. A short directed stream adds an illegal code at one stage of a valid sample, an unmarked gap, and the all-high and all-low code sets. These show the substitution for code 11, the cycle in which the error flag rises, and both extremes of the sum.

// File: rtl/pac_pkg.sv
`timescale 1ns/1ps
package pac_pkg;
   typedef logic [1:0] pac_code_t;

   localparam pac_code_t PAC_LOW  = 2'b00;
   localparam pac_code_t PAC_MID  = 2'b01;
   localparam pac_code_t PAC_HIGH = 2'b10;
   localparam pac_code_t PAC_BAD  = 2'b11;

   localparam int PAC_MIN_STAGES = 2;
   localparam int PAC_MAX_STAGES = 16;

   // Illegal decisions count as the middle level.
   function automatic pac_code_t pac_fix(pac_code_t c);
      return (c == PAC_BAD) ? PAC_MID : c;
   endfunction

   function automatic logic pac_is_bad(pac_code_t c);
      return c == PAC_BAD;
   endfunction
endpackage

// File: rtl/pac_delay_line.sv
`timescale 1ns/1ps
module pac_delay_line #(
   parameter int WIDTH = 2,
   parameter int DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("pac_delay_line: WIDTH must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("pac_delay_line: DEPTH must be at least 1");
   end

   logic [WIDTH-1:0] sr [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
      end else begin
         sr[0] <= d;
         for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
      end
   end

   assign q = sr[DEPTH-1];
endmodule

// File: rtl/pac_weighted_sum.sv
`timescale 1ns/1ps
module pac_weighted_sum
   import pac_pkg::*;
#(
   parameter int NUM_STAGES = 6,
   localparam int OUT_W  = NUM_STAGES + 1,
   localparam int CODE_W = 2 * NUM_STAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lane_valid,
   input  logic [CODE_W-1:0] lanes,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_word,
   output logic              err_sticky
);
   localparam logic [OUT_W-1:0] WORD_MAX = OUT_W'((2 ** OUT_W) - 2);

   pac_code_t             fixed [NUM_STAGES];
   logic [NUM_STAGES-1:0] bad;
   logic [OUT_W-1:0]      acc;

   for (genvar g = 0; g < NUM_STAGES; g++) begin : g_lane
      assign fixed[g] = pac_fix(lanes[2*g +: 2]);
      assign bad[g]   = pac_is_bad(lanes[2*g +: 2]);
   end

   // Lane 0 is stage 1 and carries weight 2^(K-1); the last lane weighs 1.
   always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_STAGES; i++) begin
         acc = acc + (OUT_W'(fixed[i]) << (NUM_STAGES - 1 - i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_word   <= '0;
         err_sticky <= 1'b0;
      end else begin
         out_valid <= lane_valid;
         if (lane_valid) begin
            out_word <= acc;
            if (|bad) err_sticky <= 1'b1;
         end
      end
   end

   a_r3_word_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_word <= WORD_MAX));

   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

   a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_sticky) |-> ($past(lane_valid) && out_valid));
endmodule

// File: rtl/pac_corrector.sv
`timescale 1ns/1ps
module pac_corrector
   import pac_pkg::*;
#(
   parameter int NUM_STAGES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [2*NUM_STAGES-1:0] stage_codes,
   output logic                    out_valid,
   output logic [NUM_STAGES:0]     out_word,
   output logic                    err_sticky
);
   localparam int CODE_W = 2 * NUM_STAGES;
   localparam int VALID_DEPTH = NUM_STAGES - 1;

   if (NUM_STAGES < PAC_MIN_STAGES || NUM_STAGES > PAC_MAX_STAGES) begin : g_bad_stages
      $error("pac_corrector: NUM_STAGES out of supported range");
   end

   logic [CODE_W-1:0] aligned;
   logic              align_valid;

   // Stage n (lane n-1) is delayed by K-n clocks; the last stage passes straight through.
   for (genvar g = 0; g < NUM_STAGES; g++) begin : g_align
      if (g == NUM_STAGES - 1) begin : g_direct
         assign aligned[2*g +: 2] = stage_codes[2*g +: 2];
      end else begin : g_delay
         pac_delay_line #(
            .WIDTH (2),
            .DEPTH (NUM_STAGES - 1 - g)
         ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (stage_codes[2*g +: 2]),
            .q     (aligned[2*g +: 2])
         );
      end
   end

   pac_delay_line #(
      .WIDTH (1),
      .DEPTH (VALID_DEPTH)
   ) u_valid (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (in_valid),
      .q     (align_valid)
   );

   pac_weighted_sum #(
      .NUM_STAGES (NUM_STAGES)
   ) u_sum (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_valid (align_valid),
      .lanes      (aligned),
      .out_valid  (out_valid),
      .out_word   (out_word),
      .err_sticky (err_sticky)
   );

   a_r4_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(align_valid));

   a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !align_valid |=> $stable(out_word));
endmodule

// File: tb/pac_corrector_bench.sv
`timescale 1ns/1ps
module pac_corrector_bench;
   localparam int NK   = 6;
   localparam int SCL  = 2 ** (NK + 3);   // Vref in integer units
   localparam int MAXN = 1024;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic [2*NK-1:0]     stage_codes = '0;
   logic                out_valid;
   logic [NK:0]         out_word;
   logic                err_sticky;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [2*NK-1:0] slot_codes [MAXN];
   bit              slot_valid [MAXN];
   bit              slot_bad   [MAXN];
   bit              slot_ideal [MAXN];
   int              slot_x     [MAXN];
   int              exp_word   [MAXN];
   int              held_word;
   bit              err_model;

   always #5 clk = ~clk;

   pac_corrector #(.NUM_STAGES(NK)) u_pac_corrector (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .stage_codes (stage_codes),
      .out_valid   (out_valid),
      .out_word    (out_word),
      .err_sticky  (err_sticky)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Ideal staggered stage model on an integer-scaled input (R9).
   function automatic logic [2*NK-1:0] ideal_codes(int x);
      logic [2*NK-1:0] v = '0;
      int r = x;
      for (int k = 0; k < NK; k++) begin
         if (r <= -SCL/4) begin
            v[2*k +: 2] = 2'b00; r = 2*r + SCL;
         end else if (r <= SCL/4) begin
            v[2*k +: 2] = 2'b01; r = 2*r;
         end else begin
            v[2*k +: 2] = 2'b10; r = 2*r - SCL;
         end
      end
      return v;
   endfunction

   // Weighted sum from R3, with 11 counted as 01 per R7.
   function automatic int calc_word(logic [2*NK-1:0] v);
      int s = 0;
      for (int k = 0; k < NK; k++) begin
         int c = int'(v[2*k +: 2]);
         if (c == 3) c = 1;
         s += c * (2 ** (NK - 1 - k));
      end
      return s;
   endfunction

   function automatic bit has_bad(logic [2*NK-1:0] v);
      for (int k = 0; k < NK; k++) if (v[2*k +: 2] == 2'b11) return 1'b1;
      return 1'b0;
   endfunction

   task automatic set_slot(int s, bit v, bit ideal, int x, logic [2*NK-1:0] codes);
      slot_valid[s] = v;
      slot_ideal[s] = ideal;
      slot_x[s]     = x;
      slot_codes[s] = codes;
      slot_bad[s]   = has_bad(codes);
      exp_word[s]   = calc_word(codes);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = 1'b0;
      stage_codes = '0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      chk(out_word == '0, "R1 out_word in reset", int'(out_word), 0);
      chk(err_sticky == 1'b0, "R1 err_sticky in reset", int'(err_sticky), 0);
      rst_n = 1'b1;
      held_word = 0;
      err_model = 1'b0;
   endtask

   task automatic run_stream(int n);
      for (int t = 0; t < n + NK + 1; t++) begin
         int o;
         @(negedge clk);
         o = t - NK;
         if (o >= 0 && o < n) begin
            if (slot_valid[o]) begin
               if (slot_bad[o]) err_model = 1'b1;
               held_word = exp_word[o];
               chk(out_valid == 1'b1, "R4 out_valid after K cycles", int'(out_valid), 1);
               chk(int'(out_word) == exp_word[o], "R2 R3 R7 aligned weighted sum",
                   int'(out_word), exp_word[o]);
               if (slot_ideal[o]) begin
                  int err;
                  err = int'(out_word) * SCL - ((2 ** NK) - 1) * SCL - slot_x[o] * (2 ** NK);
                  chk(err < SCL && err > -SCL, "R9 ideal quantisation", err, 0);
               end
            end else begin
               chk(out_valid == 1'b0, "R4 no output for unmarked slot", int'(out_valid), 0);
               chk(int'(out_word) == held_word, "R8 word held", int'(out_word), held_word);
            end
            chk(err_sticky == err_model, "R5 R6 error flag", int'(err_sticky), int'(err_model));
         end
         in_valid = (t < n) ? slot_valid[t] : 1'b0;
         for (int k = 0; k < NK; k++) begin
            int s = t - k;
            stage_codes[2*k +: 2] = (s >= 0 && s < n) ? slot_codes[s][2*k +: 2] : 2'b00;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      stage_codes = '0;
   endtask

   initial begin
      do_reset();

      // Sweep: every level on the grid; every seventh slot unmarked and full of 11 codes.
      for (int s = 0; s < MAXN - 1; s++) begin
         if (s % 7 == 3) set_slot(s, 1'b0, 1'b0, 0, '1);
         else            set_slot(s, 1'b1, 1'b1, s - (SCL - 1), ideal_codes(s - (SCL - 1)));
      end
      run_stream(MAXN - 1);
      chk(err_sticky == 1'b0, "R6 unmarked illegal codes ignored", int'(err_sticky), 0);

      do_reset();
      // Directed: illegal code in stage 3 of a valid sample, gap, extremes.
      begin
         logic [2*NK-1:0] v;
         set_slot(0, 1'b1, 1'b1, 100, ideal_codes(100));
         v = ideal_codes(-300);
         v[5:4] = 2'b11;
         set_slot(1, 1'b1, 1'b0, 0, v);
         set_slot(2, 1'b0, 1'b0, 0, '0);
         set_slot(3, 1'b1, 1'b1, 0, ideal_codes(0));
         set_slot(4, 1'b1, 1'b0, 0, {NK{2'b10}});
         set_slot(5, 1'b1, 1'b0, 0, {NK{2'b00}});
      end
      chk(exp_word[4] == (2 ** (NK + 1)) - 2, "R3 top code model", exp_word[4], (2 ** (NK + 1)) - 2);
      run_stream(6);
      repeat (4) @(negedge clk);
      chk(err_sticky == 1'b1, "R5 flag persists", int'(err_sticky), 1);
      chk(out_valid == 1'b0, "R4 idle after stream", int'(out_valid), 0);
      chk(int'(out_word) == 0, "R8 word held after last", int'(out_word), 0);

      do_reset();
      chk(err_sticky == 1'b0, "R1 flag cleared by reset", int'(err_sticky), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule